// File: doc/BRIEF.md
# Interrupt Pending Write Legalizer

This block holds the pending-interrupt vector of a hart and decides which of its bits a software write may change. Software reaches the vector through two views. The machine view reads the whole vector. The supervisor view reads the vector ANDed with the delegation mask. A write through either view passes through a per-bit writability mask. Bits that are not writable keep their stored value.

The mask depends on four things: the view being written, the delegation mask, the timer-compare enable, and the user-interrupt feature flag. While the timer-compare enable is on, the supervisor timer pending bit belongs to the timer hardware, and software cannot write it through either view. Hardware interrupt sources and priority selection sit outside this block.

Bit positions are fixed: user software 0, supervisor software 1, user timer 4, supervisor timer 5, user external 8, supervisor external 9. The vector width is the parameter `PEND_W`, which defaults to 16 and must be at least 10. The parameter `HAS_TCMP` (default 1) says whether the timer-compare feature exists. When it is 0, the enable input is ignored.

Top module: `irq_pend_legalizer`

## Requirements
- R1: After reset the pending vector is all zeros, and both views read zero.
- R2: A machine-view write (`wrEn`=1, `wrView`=0) replaces bits 1 (supervisor software) and 9 (supervisor external) with the write data. With `tcmpEn`=0 it also replaces bit 5 (supervisor timer). Every other bit keeps its value unless R7 applies.
- R3: With `HAS_TCMP`=1 and `tcmpEn`=1, no write through either view changes bit 5.
- R4: A supervisor-view write (`wrView`=1) changes bit 1 only when `delegMask[1]` is 1.
- R5: A supervisor-view write changes bit 5 only when `delegMask[5]` is 1 and `tcmpEn` is 0.
- R6: A supervisor-view write never changes bit 9 or any bit outside {0,1,4,5,8}.
- R7: With `userIntEn`=1, a machine-view write also replaces bits 0, 4 and 8. With `userIntEn`=0, a machine-view write leaves those bits unchanged.
- R8: With `userIntEn`=1, a supervisor-view write replaces each of bits 0, 4 and 8 whose delegation bit is 1. It leaves the others unchanged.
- R9: `pendS` always equals `pendM` ANDed with `delegMask`, in the same cycle.
- R10: A write shows on `pendM` from the first rising clock edge after the strobe and not before. Without a write strobe the vector stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the pending register |
| wrView | input | 1 | View being written: 0 machine, 1 supervisor |
| wrData | input | PEND_W | Software write value |
| delegMask | input | PEND_W | Delegation mask |
| tcmpEn | input | 1 | Timer-compare enable; when set, hardware owns bit 5 |
| userIntEn | input | 1 | User-level interrupt feature flag |
| pendM | output | PEND_W | Machine view of the pending vector |
| pendS | output | PEND_W | Supervisor view: pending ANDed with delegation |

## Verification
A wrong writability decision leaves a stored bit wrong, and the error shows on `pendM` at the first falling edge after the write's clock edge. The error persists until a later legal write corrects that bit, so a cycle-by-cycle comparison catches it at once. The comparison runs against a behavioural model with both views checked. Mistakes in the delegation gating show on `pendS` only for delegated bits. For that reason the stimulus sweeps delegation masks, toggles `tcmpEn`, toggles `userIntEn`, and alternates the two views.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int BitUsi = 0;
  localparam int BitSsi = 1;
  localparam int BitUti = 4;
  localparam int BitSti = 5;
  localparam int BitUei = 8;
  localparam int BitSei = 9;

  typedef enum logic {
    VIEW_MACH = 1'b0,
    VIEW_SUP  = 1'b1
  } pendView_e;

  typedef struct packed {
    logic mWr;       // machine-view write this cycle
    logic sWr;       // supervisor-view write this cycle
    logic stiOpen;   // supervisor timer bit writable by software
    logic userOpen;  // user bits writable by software
  } pendStrobe_t;

endpackage

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter bit HAS_TCMP = 1'b1
) (
  input  logic        wrEn,
  input  logic        wrView,
  input  logic        tcmpEn,
  input  logic        userIntEn,
  output pendStrobe_t strobe
);

  pendView_e view;

  always_comb begin
    view            = pendView_e'(wrView);
    strobe.mWr      = wrEn && (view == VIEW_MACH);
    strobe.sWr      = wrEn && (view == VIEW_SUP);
    strobe.userOpen = userIntEn;
    if (HAS_TCMP) strobe.stiOpen = !tcmpEn;
    else          strobe.stiOpen = 1'b1;
  end

endmodule

// File: rtl/irq_pend_dpath.sv
module irq_pend_dpath
  import irq_pend_pkg::*;
#(
  parameter int PEND_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pendStrobe_t       strobe,
  input  logic [PEND_W-1:0] wrData,
  input  logic [PEND_W-1:0] delegMask,
  output logic [PEND_W-1:0] pendM,
  output logic [PEND_W-1:0] pendS
);

  localparam logic [PEND_W-1:0] SupWritable =
    PEND_W'((1 << BitUsi) | (1 << BitSsi) | (1 << BitUti) | (1 << BitSti) | (1 << BitUei));

  logic [PEND_W-1:0] pendQ;
  logic [PEND_W-1:0] wMask;
  logic [PEND_W-1:0] pendNext;

  for (genvar i = 0; i < PEND_W; i++) begin : g_bit
    if (i == BitSsi) begin : g_ssi
      assign wMask[i] = strobe.mWr | (strobe.sWr & delegMask[i]);
    end else if (i == BitSei) begin : g_sei
      assign wMask[i] = strobe.mWr;
    end else if (i == BitSti) begin : g_sti
      assign wMask[i] = strobe.stiOpen & (strobe.mWr | (strobe.sWr & delegMask[i]));
    end else if (i == BitUsi || i == BitUti || i == BitUei) begin : g_user
      assign wMask[i] = strobe.userOpen & (strobe.mWr | (strobe.sWr & delegMask[i]));
    end else begin : g_ro
      assign wMask[i] = 1'b0;
    end
  end

  assign pendNext = (pendQ & ~wMask) | (wrData & wMask);

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  assign pendM = pendQ;
  assign pendS = pendQ & delegMask;

  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.mWr || strobe.sWr) |=> $stable(pendQ));

  a_r3_sti_locked: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stiOpen |=> $stable(pendQ[BitSti]));

  a_r6_sup_write_scope: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sWr |=> ((pendQ & ~SupWritable) == $past(pendQ & ~SupWritable)));

  a_r4_ssi_undelegated: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sWr && !delegMask[BitSsi]) |=> $stable(pendQ[BitSsi]));

  a_r2_mach_write_ssi: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mWr |=> (pendQ[BitSsi] == $past(wrData[BitSsi])));

  a_r7_user_closed: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.userOpen |=> ($stable(pendQ[BitUsi]) && $stable(pendQ[BitUti]) && $stable(pendQ[BitUei])));

endmodule

// File: rtl/irq_pend_legalizer.sv
module irq_pend_legalizer
  import irq_pend_pkg::*;
#(
  parameter int PEND_W   = 16,
  parameter bit HAS_TCMP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrView,
  input  logic [PEND_W-1:0] wrData,
  input  logic [PEND_W-1:0] delegMask,
  input  logic              tcmpEn,
  input  logic              userIntEn,
  output logic [PEND_W-1:0] pendM,
  output logic [PEND_W-1:0] pendS
);

  pendStrobe_t strobe;

  irq_pend_ctrl #(.HAS_TCMP(HAS_TCMP)) u_ctrl (
    .wrEn      (wrEn),
    .wrView    (wrView),
    .tcmpEn    (tcmpEn),
    .userIntEn (userIntEn),
    .strobe    (strobe)
  );

  irq_pend_dpath #(.PEND_W(PEND_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .delegMask (delegMask),
    .pendM     (pendM),
    .pendS     (pendS)
  );

  a_r9_sup_view: assert property (@(posedge clk) disable iff (!rstN)
    pendS == (pendM & delegMask));

endmodule

// File: tb/sim_irq_pend_legalizer.sv
`timescale 1ns/1ps
module sim_irq_pend_legalizer;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrView = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] delegMask = '0;
  logic         tcmpEn = 1'b0;
  logic         userIntEn = 1'b0;
  logic [W-1:0] pendM;
  logic [W-1:0] pendS;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] refPend = '0;

  always #2.5 clk = ~clk;

  irq_pend_legalizer #(.PEND_W(W), .HAS_TCMP(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrView(wrView), .wrData(wrData),
    .delegMask(delegMask), .tcmpEn(tcmpEn), .userIntEn(userIntEn),
    .pendM(pendM), .pendS(pendS)
  );

  function automatic logic [W-1:0] modelWrite(logic [W-1:0] cur, logic sup, logic [W-1:0] d,
                                              logic [W-1:0] dg, logic tc, logic ue);
    logic [W-1:0] r = cur;
    if (!sup) begin
      r[1] = d[1];
      r[9] = d[9];
      if (!tc) r[5] = d[5];
      if (ue) begin r[0] = d[0]; r[4] = d[4]; r[8] = d[8]; end
    end else begin
      if (dg[1]) r[1] = d[1];
      if (dg[5] && !tc) r[5] = d[5];
      if (ue) begin
        if (dg[0]) r[0] = d[0];
        if (dg[4]) r[4] = d[4];
        if (dg[8]) r[8] = d[8];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare both views at next negedge
  task automatic cycle(logic we, logic sup, logic [W-1:0] d, logic [W-1:0] dg,
                       logic tc, logic ue, string tag);
    wrEn = we; wrView = sup; wrData = d; delegMask = dg; tcmpEn = tc; userIntEn = ue;
    @(posedge clk);
    if (we) refPend = modelWrite(refPend, sup, d, dg, tc, ue);
    @(negedge clk);
    wrEn = 1'b0;
    check(tag, pendM, refPend);
    check("R9", pendS, refPend & dg);
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", pendM, '0);
    check("R1", pendS, '0);

    // R2: machine write of all ones, timer-compare off, user off
    cycle(1, 0, 16'hFFFF, 16'h0000, 0, 0, "R2");
    check("R2", pendM, 16'h0222);
    // R3: enable on, clearing write leaves bit 5
    cycle(1, 0, 16'h0000, 16'h0000, 1, 0, "R3");
    check("R3", pendM, 16'h0020);
    cycle(1, 0, 16'h0000, 16'h0000, 0, 0, "R2");
    check("R2", pendM, 16'h0000);

    // R4/R6: supervisor write without delegation
    cycle(1, 1, 16'hFFFF, 16'h0000, 0, 1, "R4");
    check("R6", pendM, 16'h0000);
    cycle(1, 1, 16'hFFFF, 16'h0002, 0, 0, "R4");
    check("R4", pendM, 16'h0002);
    // R5: fully delegated, enable on -> bit 5 locked; bit 9 never
    cycle(1, 1, 16'hFFFF, 16'hFFFF, 1, 0, "R5");
    check("R5", pendM, 16'h0002);
    cycle(1, 1, 16'hFFFF, 16'hFFFF, 0, 0, "R5");
    check("R5", pendM, 16'h0022);
    cycle(1, 1, 16'hFFFF, 16'hFFDF, 0, 0, "R5");

    // R7: user bits through machine view
    cycle(1, 0, 16'hFFFF, 16'h0000, 0, 1, "R7");
    check("R7", pendM, 16'h0333);
    cycle(1, 0, 16'h0000, 16'h0000, 0, 0, "R7");
    check("R7", pendM, 16'h0111);
    // R8: delegated user bit only
    cycle(1, 1, 16'h0000, 16'h0010, 0, 1, "R8");
    check("R8", pendM, 16'h0101);
    cycle(1, 1, 16'h0000, 16'h0101, 0, 0, "R8");
    check("R8", pendM, 16'h0101);

    // R9: supervisor view tracks delegation with no write
    delegMask = 16'h0100;
    #1 check("R9", pendS, 16'h0100);
    delegMask = 16'h0001;
    #1 check("R9", pendS, 16'h0001);

    // R10: not visible before the edge, visible after; hold without strobe
    @(negedge clk);
    wrEn = 1'b1; wrView = 1'b0; wrData = 16'h0200; tcmpEn = 1'b0; userIntEn = 1'b0;
    #1 check("R10", pendM, 16'h0101);
    @(posedge clk);
    refPend = modelWrite(refPend, 0, 16'h0200, delegMask, 0, 0);
    @(negedge clk);
    wrEn = 1'b0;
    check("R10", pendM, 16'h0301);
    for (int k = 0; k < 4; k++) cycle(0, 0, 16'hFFFF, 16'hFFFF, 0, 1, "R10");

    // mixed stimulus against the model
    for (int k = 0; k < 400; k++) begin
      cycle(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
            1'($urandom), 1'($urandom), "R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule